// File: doc/BRIEF.md
# Time-of-Day Counter with Hourly Chime

This block keeps 24-hour wall-clock time for a six-digit display. One system clock drives every register. A one-cycle pulse, `tickEn`, arrives once per second and works as a clock enable. Hours, minutes and seconds are each held as a pair of BCD digits, tens and units. The seconds stage wraps into the minutes stage, and the minutes stage wraps into the hours stage. A downstream display driver reads the six digits straight from the outputs.

Two raw push buttons, both active low, set the time. While the minute button is held, the minutes advance by one on every tick. While the hour button is held, the hours advance by one on every tick. Each button is sampled only on ticks, into a short history register, and this history filters out contact bounce. At midnight and at noon the block raises a buzzer enable for two seconds. An asynchronous active-low reset returns the time to 00:00:00 and silences the buzzer.

Top module: `digital_clock_core`

## Requirements
- R1: Seconds and minutes count 0..59 and hours count 0..23. Each field is presented as a tens digit and a units digit in 4-bit BCD. From its last value a field wraps to 00.
- R2: A tick that moves the seconds from 59 to 00 also advances the minutes by one. A tick that moves both the seconds and the minutes from 59 to 00 also advances the hours by one.
- R3: While `rstN` is low, all six digits read 0 and `buzzer` reads 0. This takes effect without waiting for a clock edge. After release, counting continues from 00:00:00.
- R4: The digits change only on a rising clock edge where `tickEn` is 1. Such an edge moves the seconds by exactly one. In all other cycles the digits hold their value.
- R5: While the minute key counts as held, every tick advances the minutes by one and the seconds-to-minutes carry is ignored. A wrap of the minutes from 59 to 00 in this state does not advance the hours.
- R6: While the hour key counts as held, every tick advances the hours by one, and the hours wrap from 23 to 00.
- R7: On every tick, each key's input level is shifted into a 3-deep sample history. A key counts as held on a tick if any of the three samples taken on earlier ticks is 0. A key held down therefore first acts on the second tick after the press. It keeps acting for three ticks after it is released.
- R8: With both keys held, minutes and hours each advance by one on the same tick.
- R9: If a tick brings the time to 00:00:00 or 12:00:00, `buzzer` rises one clock cycle later. It stays high until the edge of the second tick that follows, and then falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | One-cycle pulse, once per second |
| minSetN | input | 1 | Minute-set button, raw, active low |
| hourSetN | input | 1 | Hour-set button, raw, active low |
| hourTens | output | 4 | Hours, tens digit (BCD) |
| hourUnits | output | 4 | Hours, units digit (BCD) |
| minTens | output | 4 | Minutes, tens digit (BCD) |
| minUnits | output | 4 | Minutes, units digit (BCD) |
| secTens | output | 4 | Seconds, tens digit (BCD) |
| secUnits | output | 4 | Seconds, units digit (BCD) |
| buzzer | output | 1 | Chime enable |

## Verification
The assertions check the following on every cycle:
- every digit stays within its legal BCD range;
- a field at its last value returns to 00 when it is stepped;
- the digits hold still between ticks;
- a key sampled low counts as held;
- the buzzer only rises just after the time reaches a chime time, and it cannot drop between ticks.

Other behaviours depend on the sequence of ticks and button levels, so only the bench's scenarios can show them:
- the carry chain across minute and hour boundaries;
- the ticks lost to filtering when a key is pressed or released;
- a minute wrap that does not carry while setting;
- both keys held at once;
- the two-second length of the midnight and noon chimes.

// File: rtl/clock_core_pkg.sv
package clock_core_pkg;
  // Per-tick advance requests from control to datapath
  typedef struct packed {
    logic secStep;
    logic minStep;
    logic hourStep;
  } stepStrobes_t;
endpackage

// File: rtl/clock_bcd_field.sv
module clock_bcd_field #(
  parameter int MODULUS = 60
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       step,
  output logic [3:0] tensDigit,
  output logic [3:0] unitsDigit,
  output logic       atLast,
  output logic       atZero
);
  localparam logic [3:0] LAST_TENS  = 4'((MODULUS - 1) / 10);
  localparam logic [3:0] LAST_UNITS = 4'((MODULUS - 1) % 10);

  logic [3:0] tensQ, unitsQ;

  assign atLast = (tensQ == LAST_TENS) && (unitsQ == LAST_UNITS);
  assign atZero = (tensQ == 4'd0) && (unitsQ == 4'd0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tensQ  <= 4'd0;
      unitsQ <= 4'd0;
    end else if (step) begin
      if (atLast) begin
        tensQ  <= 4'd0;
        unitsQ <= 4'd0;
      end else if (unitsQ == 4'd9) begin
        tensQ  <= tensQ + 4'd1;
        unitsQ <= 4'd0;
      end else begin
        unitsQ <= unitsQ + 4'd1;
      end
    end
  end

  assign tensDigit  = tensQ;
  assign unitsDigit = unitsQ;

  // R1
  field_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (step && atLast) |=> (tensDigit == 4'd0 && unitsDigit == 4'd0));

  // R1
  digit_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (unitsDigit <= 4'd9) && (tensDigit <= LAST_TENS));
endmodule

// File: rtl/clock_ctrl.sv
module clock_ctrl
  import clock_core_pkg::*;
#(
  parameter int DEBOUNCE_DEPTH = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tickEn,
  input  logic         minSetN,
  input  logic         hourSetN,
  input  logic         secLast,
  input  logic         minLast,
  output stepStrobes_t strb
);
  localparam int NUM_KEYS = 2;

  logic [NUM_KEYS-1:0] keyRawN;
  logic [NUM_KEYS-1:0] keyHeld;

  assign keyRawN = {hourSetN, minSetN};

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    logic [DEBOUNCE_DEPTH-1:0] sampHist;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       sampHist <= '1;
      else if (tickEn) sampHist <= {sampHist[DEBOUNCE_DEPTH-2:0], keyRawN[k]};
    end

    assign keyHeld[k] = ~&sampHist;

    // R7
    key_sample_held_chk: assert property (@(posedge clk) disable iff (!rstN)
      (tickEn && !keyRawN[k]) |=> keyHeld[k]);
  end

  logic minHeld, hourHeld;
  assign minHeld  = keyHeld[0];
  assign hourHeld = keyHeld[1];

  always_comb begin
    strb.secStep  = tickEn;
    strb.minStep  = tickEn && (minHeld || secLast);
    strb.hourStep = tickEn && (hourHeld || (!minHeld && secLast && minLast));
  end
endmodule

// File: rtl/clock_dp.sv
module clock_dp
  import clock_core_pkg::*;
#(
  parameter int CHIME_TICKS = 2,
  parameter int CHIME_HOUR_A = 0,
  parameter int CHIME_HOUR_B = 12
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tickEn,
  input  stepStrobes_t strb,
  output logic [3:0]   hourTens,
  output logic [3:0]   hourUnits,
  output logic [3:0]   minTens,
  output logic [3:0]   minUnits,
  output logic [3:0]   secTens,
  output logic [3:0]   secUnits,
  output logic         secLast,
  output logic         minLast,
  output logic         buzzer
);
  localparam int CW = $clog2(CHIME_TICKS + 1);
  localparam logic [3:0] A_TENS  = 4'(CHIME_HOUR_A / 10);
  localparam logic [3:0] A_UNITS = 4'(CHIME_HOUR_A % 10);
  localparam logic [3:0] B_TENS  = 4'(CHIME_HOUR_B / 10);
  localparam logic [3:0] B_UNITS = 4'(CHIME_HOUR_B % 10);

  logic secZero, minZero, hourLast, hourZero;

  clock_bcd_field #(.MODULUS(60)) i_sec (
    .clk(clk), .rstN(rstN), .step(strb.secStep),
    .tensDigit(secTens), .unitsDigit(secUnits), .atLast(secLast), .atZero(secZero));

  clock_bcd_field #(.MODULUS(60)) i_min (
    .clk(clk), .rstN(rstN), .step(strb.minStep),
    .tensDigit(minTens), .unitsDigit(minUnits), .atLast(minLast), .atZero(minZero));

  clock_bcd_field #(.MODULUS(24)) i_hour (
    .clk(clk), .rstN(rstN), .step(strb.hourStep),
    .tensDigit(hourTens), .unitsDigit(hourUnits), .atLast(hourLast), .atZero(hourZero));

  logic atChimeTime;
  assign atChimeTime = secZero && minZero &&
    ((hourTens == A_TENS && hourUnits == A_UNITS) ||
     (hourTens == B_TENS && hourUnits == B_UNITS));

  logic          tickDly;
  logic [CW-1:0] chimeLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickDly   <= 1'b0;
      chimeLeft <= '0;
    end else begin
      tickDly <= tickEn;
      if (tickDly && atChimeTime)
        chimeLeft <= CW'(CHIME_TICKS);
      else if (tickEn && chimeLeft != '0)
        chimeLeft <= chimeLeft - 1'b1;
    end
  end

  assign buzzer = (chimeLeft != '0);

  // R4
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable({hourTens, hourUnits, minTens, minUnits, secTens, secUnits}));

  // R9
  chime_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(buzzer) |-> atChimeTime);

  // R9
  chime_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (buzzer && !tickEn && !tickDly) |=> buzzer);
endmodule

// File: rtl/digital_clock_core.sv
module digital_clock_core
  import clock_core_pkg::*;
#(
  parameter int DEBOUNCE_DEPTH = 3,
  parameter int CHIME_TICKS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       minSetN,
  input  logic       hourSetN,
  output logic [3:0] hourTens,
  output logic [3:0] hourUnits,
  output logic [3:0] minTens,
  output logic [3:0] minUnits,
  output logic [3:0] secTens,
  output logic [3:0] secUnits,
  output logic       buzzer
);
  stepStrobes_t strb;
  logic secLast, minLast;

  clock_ctrl #(.DEBOUNCE_DEPTH(DEBOUNCE_DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .minSetN(minSetN), .hourSetN(hourSetN),
    .secLast(secLast), .minLast(minLast), .strb(strb));

  clock_dp #(.CHIME_TICKS(CHIME_TICKS), .CHIME_HOUR_A(0), .CHIME_HOUR_B(12)) i_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strb(strb),
    .hourTens(hourTens), .hourUnits(hourUnits),
    .minTens(minTens), .minUnits(minUnits),
    .secTens(secTens), .secUnits(secUnits),
    .secLast(secLast), .minLast(minLast), .buzzer(buzzer));
endmodule

// File: tb/test_digital_clock_core.sv
module test_digital_clock_core;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic minSetN = 1'b1;
  logic hourSetN = 1'b1;
  logic [3:0] hourTens, hourUnits, minTens, minUnits, secTens, secUnits;
  logic buzzer;

  always #5 clk = ~clk;

  digital_clock_core i_digital_clock_core (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .minSetN(minSetN), .hourSetN(hourSetN),
    .hourTens(hourTens), .hourUnits(hourUnits),
    .minTens(minTens), .minUnits(minUnits),
    .secTens(secTens), .secUnits(secUnits), .buzzer(buzzer));

  typedef struct {
    int    h, m, s;
    bit    bz;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int nChecks = 0;
  int nFails = 0;

  // reference model state
  int mh = 0, mm = 0, ms = 0, chimeCnt = 0;
  logic [2:0] minHist = 3'b111, hourHist = 3'b111;

  function automatic int asInt(logic [3:0] t, logic [3:0] u);
    return int'(t) * 10 + int'(u);
  endfunction

  task automatic compare(string tag, int h, int m, int s, bit bz);
    nChecks++;
    if (asInt(hourTens, hourUnits) != h || asInt(minTens, minUnits) != m ||
        asInt(secTens, secUnits) != s || buzzer != bz ||
        hourUnits > 9 || minUnits > 9 || secUnits > 9) begin
      nFails++;
      $display("FAIL %s: got %0d%0d:%0d%0d:%0d%0d buzz=%0b, expected %02d:%02d:%02d buzz=%0b",
               tag, hourTens, hourUnits, minTens, minUnits, secTens, secUnits, buzzer,
               h, m, s, bz);
    end
  endtask

  // monitor: pops each expected item one cycle after it was pushed
  always @(negedge clk) begin
    if (expQ.size() != 0) begin
      expItem_t it;
      it = expQ.pop_front();
      compare(it.tag, it.h, it.m, it.s, it.bz);
    end
  end

  task automatic modelTick();
    bit minH, hourH, sl, ml, stepM, stepH;
    minH  = (minHist != 3'b111);
    hourH = (hourHist != 3'b111);
    sl = (ms == 59);
    ml = (mm == 59);
    stepM = minH || sl;
    stepH = hourH || (!minH && sl && ml);
    ms = (ms + 1) % 60;
    if (stepM) mm = (mm + 1) % 60;
    if (stepH) mh = (mh + 1) % 24;
    minHist  = {minHist[1:0], minSetN};
    hourHist = {hourHist[1:0], hourSetN};
    if (chimeCnt > 0) chimeCnt--;
    if (ms == 0 && mm == 0 && (mh == 0 || mh == 12)) chimeCnt = 2;
  endtask

  // driver: one tick pulse, expected result pushed for the monitor
  task automatic doTick(string tag);
    expItem_t it;
    @(negedge clk);
    tickEn = 1'b1;
    modelTick();
    @(negedge clk);
    tickEn = 1'b0;
    #1;
    it.h = mh; it.m = mm; it.s = ms; it.bz = (chimeCnt > 0); it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic runTicks(int n, string tag);
    for (int i = 0; i < n; i++) doTick(tag);
  endtask

  task automatic modelReset();
    mh = 0; mm = 0; ms = 0; chimeCnt = 0;
    minHist = 3'b111; hourHist = 3'b111;
  endtask

  task automatic setMinutes(int target);
    minSetN = 1'b0;
    runTicks(4, "R5 R7");
    for (int i = 0; i < 200 && mm != (target + 57) % 60; i++) doTick("R5");
    minSetN = 1'b1;
    runTicks(3, "R5 R7");
  endtask

  task automatic setHours(int target);
    hourSetN = 1'b0;
    runTicks(4, "R6 R7");
    for (int i = 0; i < 100 && mh != (target + 21) % 24; i++) doTick("R6");
    hourSetN = 1'b1;
    runTicks(3, "R6 R7");
  endtask

  task automatic runUntilChime(string tag);
    for (int i = 0; i < 4000 && !(ms == 0 && mm == 0 && (mh == 0 || mh == 12)); i++)
      doTick("R2");
    // the item pushed for this boundary already expects the buzzer high
    runTicks(1, tag);
    runTicks(1, tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    // R3: reset state
    #2;
    compare("R3 reset state", 0, 0, 0, 1'b0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compare("R3 after release", 0, 0, 0, 1'b0);

    // R4: no change without a tick
    repeat (10) @(negedge clk);
    compare("R4 idle hold", 0, 0, 0, 1'b0);

    // R1 R2 R4: seconds wrap and minute carry
    runTicks(65, "R1 R2 R4");

    // R5 R7: press minute key, hold through a minute wrap
    minSetN = 1'b0;
    runTicks(64, "R5 R7");
    minSetN = 1'b1;
    runTicks(5, "R5 R7");

    // R6: hour key, wrap 23 to 0
    hourSetN = 1'b0;
    runTicks(27, "R6");
    hourSetN = 1'b1;
    runTicks(4, "R6 R7");

    // R8: both keys
    minSetN = 1'b0;
    hourSetN = 1'b0;
    runTicks(8, "R8");
    minSetN = 1'b1;
    hourSetN = 1'b1;
    runTicks(4, "R8 R7");

    // R9 midnight: bring to 23:59 then run
    setHours(23);
    setMinutes(59);
    runUntilChime("R9 midnight");

    // R3: reset mid-run, then resume
    runTicks(3, "R2");
    @(negedge clk);
    rstN = 1'b0;
    #2;
    compare("R3 reset mid-run", 0, 0, 0, 1'b0);
    modelReset();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    runTicks(3, "R3 resume");

    // R9 noon
    setHours(11);
    setMinutes(59);
    runUntilChime("R9 noon");

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule